// File: doc/BRIEF.md
# JTAG Test Access Port with Length-Selectable Data Path

This block is a test access port clocked by the test clock. It contains the standard sixteen-state controller, which TMS steers and which an active-low test reset can also force into Test-Logic-Reset. A three-bit instruction is shifted in during an IR-Scan. When the instruction is updated it is decoded into a data-path selection, and that selection decides which serial register links TDI to TDO in every later DR-Scan. The paths are a one-bit bypass cell, a ten-bit debug register and a three-bit programming register.

The debug and programming registers each have a parallel side for the host logic. On the falling clock edge in Update-DR, the selected register presents its shifted-in word and raises an update strobe. On that same edge it samples a host-supplied load word, which becomes the next read-out. TDO changes on falling edges and is enabled only while a shift state is active.

Top module: `jtag_tap_dr`

## Requirements
- R1: The controller follows the standard sixteen-state TMS graph. Five rising edges with TMS=1 reach Test-Logic-Reset from any state, and trst_n low at a rising edge forces Test-Logic-Reset.
- R2: Test-Logic-Reset sets the instruction to 111 and selects the one-bit bypass path.
- R3: Capture-IR loads 001 into the instruction shifter, which shifts out on TDO least significant bit first during Shift-IR.
- R4: Instruction codes 011, 101 and 111 select bypass. The bypass cell captures 0 in Capture-DR, and TDO then repeats TDI one shift later.
- R5: Instruction code 010 selects the ten-bit debug register, which is shifted LSB first with TDI entering at the top bit.
- R6: Instruction code 100 selects the three-bit programming register, which is shifted the same way.
- R7: Instruction codes 000, 001 and 110 are accepted but leave the current data-path selection unchanged.
- R8: On the falling edge in Update-DR, only the selected private register drives its write word to the shifted-in pattern and raises its update strobe for one clock period.
- R9: On that same falling edge, the selected register samples its load input. The next DR-Scan shifts this value out first, because Capture-DR leaves the private registers unchanged.
- R10: No DR-Scan activity changes the instruction register.
- R11: TDO and tdo_oe change only on falling edges, and tdo_oe is high only in Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Synchronous active-low test reset |
| tms | input | 1 | Mode select that steers the controller |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, valid when tdo_oe is high |
| tdo_oe | output | 1 | Output enable that models the high-impedance TDO driver |
| dbg_upd | output | 1 | Debug register update strobe |
| dbg_wdata | output | 10 | Word shifted into the debug register |
| dbg_load | input | 10 | Value the debug register shifts out next |
| prg_upd | output | 1 | Programming register update strobe |
| prg_wdata | output | 3 | Word shifted into the programming register |
| prg_load | input | 3 | Value the programming register shifts out next |

## Verification
The assertions assume that TMS and TDI change only while the clock is low, away from both edges. They also assume that trst_n is applied long enough to reach a falling edge, so the instruction and selection registers are reset before any check is enabled. The bench changes every input one time unit after a falling edge and holds it through the next rising edge. Reset is held for two full clock periods. The sweep loads each of the eight instruction codes after each of the three possible prior selections, and it measures the resulting path length from the TDI-to-TDO delay.

// File: rtl/jtag_tap_pkg.sv
// Shared types for the test access port: controller states, data-path
// selection and instruction codes. Assumes a three-bit instruction.
package jtag_tap_pkg;

    localparam int IR_W = 3;

    typedef enum logic [3:0] {
        ST_TLR, ST_RTI,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_t;

    typedef enum logic [1:0] {
        SEL_BYP = 2'd0,
        SEL_DBG = 2'd1,
        SEL_PRG = 2'd2
    } path_sel_t;

    localparam logic [IR_W-1:0] OP_DEBUG   = 3'b010;
    localparam logic [IR_W-1:0] OP_PROG    = 3'b100;
    localparam logic [IR_W-1:0] OP_RESET   = 3'b111;
    localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

endpackage

// File: rtl/tap_fsm.sv
// Sixteen-state controller. Advances on rising TCK and is steered by TMS.
// Assumes TMS is stable around the rising edge. rst_n is synchronous.
module tap_fsm
    import jtag_tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_t state
);

    tap_state_t nxt;

    // Next-state selection from the standard TMS graph
    always_comb begin
        case (state)
            ST_TLR:    nxt = tms ? ST_TLR    : ST_RTI;
            ST_RTI:    nxt = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PA_DR;
            ST_PA_DR:  nxt = tms ? ST_EX2_DR : ST_PA_DR;
            ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: nxt = tms ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PA_IR;
            ST_PA_IR:  nxt = tms ? ST_EX2_IR : ST_PA_IR;
            ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_RTI;
            default:   nxt = ST_TLR;
        endcase
    end

    // State register with synchronous test reset
    always_ff @(posedge tck) begin
        if (!rst_n) state <= ST_TLR;
        else        state <= nxt;
    end

endmodule

// File: rtl/tap_ir.sv
// Instruction shifter, instruction latch and data-path decode.
// The shifter moves on rising TCK. The latch and decode update on falling
// TCK in Update-IR. No-op and reserved codes keep the previous selection.
module tap_ir
    import jtag_tap_pkg::*;
(
    input  logic             tck,
    input  logic             rst_n,
    input  tap_state_t       state,
    input  logic             tdi,
    output logic [IR_W-1:0]  ir_sr,
    output logic [IR_W-1:0]  ir_q,
    output path_sel_t        sel
);

    // Instruction shifter: capture the fixed pattern, then shift LSB first
    always_ff @(posedge tck) begin
        if (!rst_n)                  ir_sr <= '0;
        else if (state == ST_CAP_IR) ir_sr <= IR_CAPTURE;
        else if (state == ST_SH_IR)  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end

    // Instruction latch and decode on the falling edge
    always_ff @(negedge tck) begin
        if (!rst_n || state == ST_TLR) begin
            ir_q <= OP_RESET;
            sel  <= SEL_BYP;
        end else if (state == ST_UPD_IR) begin
            ir_q <= ir_sr;
            case (ir_sr)
                OP_DEBUG:                  sel <= SEL_DBG;
                OP_PROG:                   sel <= SEL_PRG;
                3'b011, 3'b101, 3'b111:    sel <= SEL_BYP;
                default:                   sel <= sel;
            endcase
        end
    end

endmodule

// File: rtl/tap_dr_chain.sv
// One private data register of width W (W >= 2), with a parallel side.
// It shifts on rising TCK while selected in Shift-DR. On the falling edge
// in Update-DR it presents the shifted word, raises a strobe for one period
// and snapshots the load value. It reloads from that snapshot on the rising
// edge that leaves Update-DR. Capture-DR leaves the contents unchanged.
module tap_dr_chain #(
    parameter int W = 10
) (
    input  logic         tck,
    input  logic         rst_n,
    input  logic         sel_me,
    input  logic         shift_st,
    input  logic         update_st,
    input  logic         tdi,
    input  logic [W-1:0] load_val,
    output logic         lsb,
    output logic         upd,
    output logic [W-1:0] wdata
);

    logic [W-1:0] sr;
    logic [W-1:0] snap;

    // Serial register: shift while selected, reload after an update
    always_ff @(posedge tck) begin
        if (!rst_n)                    sr <= '0;
        else if (sel_me && shift_st)   sr <= {tdi, sr[W-1:1]};
        else if (sel_me && update_st)  sr <= snap;
    end

    // Falling-edge update: write word, strobe and load snapshot
    always_ff @(negedge tck) begin
        if (!rst_n) begin
            upd   <= 1'b0;
            wdata <= '0;
            snap  <= '0;
        end else begin
            upd <= sel_me && update_st;
            if (sel_me && update_st) begin
                wdata <= sr;
                snap  <= load_val;
            end
        end
    end

    assign lsb = sr[0];

endmodule

// File: rtl/jtag_tap_dr.sv
// Top level of the test access port. It links the controller, the
// instruction logic, the bypass cell and the two private data registers,
// and registers TDO with its enable on the falling edge.
// Assumes inputs change only while TCK is low.
module jtag_tap_dr
    import jtag_tap_pkg::*;
#(
    parameter int DBG_W = 10,
    parameter int PRG_W = 3
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tms,
    input  logic             tdi,
    output logic             tdo,
    output logic             tdo_oe,
    output logic             dbg_upd,
    output logic [DBG_W-1:0] dbg_wdata,
    input  logic [DBG_W-1:0] dbg_load,
    output logic             prg_upd,
    output logic [PRG_W-1:0] prg_wdata,
    input  logic [PRG_W-1:0] prg_load
);

    tap_state_t      state;
    logic [IR_W-1:0] ir_sr;
    logic [IR_W-1:0] ir_q;
    path_sel_t       sel;
    logic            byp_q;
    logic            dbg_lsb;
    logic            prg_lsb;
    logic            dr_lsb;

    tap_fsm u_fsm (.tck(tck), .rst_n(trst_n), .tms(tms), .state(state));

    tap_ir u_ir (
        .tck(tck), .rst_n(trst_n), .state(state), .tdi(tdi),
        .ir_sr(ir_sr), .ir_q(ir_q), .sel(sel)
    );

    tap_dr_chain #(.W(DBG_W)) u_dbg (
        .tck(tck), .rst_n(trst_n), .sel_me(sel == SEL_DBG),
        .shift_st(state == ST_SH_DR), .update_st(state == ST_UPD_DR),
        .tdi(tdi), .load_val(dbg_load), .lsb(dbg_lsb),
        .upd(dbg_upd), .wdata(dbg_wdata)
    );

    tap_dr_chain #(.W(PRG_W)) u_prg (
        .tck(tck), .rst_n(trst_n), .sel_me(sel == SEL_PRG),
        .shift_st(state == ST_SH_DR), .update_st(state == ST_UPD_DR),
        .tdi(tdi), .load_val(prg_load), .lsb(prg_lsb),
        .upd(prg_upd), .wdata(prg_wdata)
    );

    // Bypass cell: captures zero, then passes TDI through one stage
    always_ff @(posedge tck) begin
        if (!trst_n)                                   byp_q <= 1'b0;
        else if (sel == SEL_BYP && state == ST_CAP_DR) byp_q <= 1'b0;
        else if (sel == SEL_BYP && state == ST_SH_DR)  byp_q <= tdi;
    end

    // Data-path output mux by current selection
    always_comb begin
        case (sel)
            SEL_DBG: dr_lsb = dbg_lsb;
            SEL_PRG: dr_lsb = prg_lsb;
            default: dr_lsb = byp_q;
        endcase
    end

    // TDO and its enable, updated on the falling edge
    always_ff @(negedge tck) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo_oe <= (state == ST_SH_IR) || (state == ST_SH_DR);
            if (state == ST_SH_IR)      tdo <= ir_sr[0];
            else if (state == ST_SH_DR) tdo <= dr_lsb;
        end
    end

endmodule

// File: rtl/tap_checker.sv
// Assertion checker bound to the test access port top.
// Assumes trst_n is held across at least one falling edge at start-up.
module tap_checker
    import jtag_tap_pkg::*;
(
    input logic            tck,
    input logic            trst_n,
    input tap_state_t      state,
    input logic [IR_W-1:0] ir_sr,
    input logic [IR_W-1:0] ir_q,
    input path_sel_t       sel,
    input logic            tdo_oe,
    input logic            dbg_upd,
    input logic            prg_upd
);

    AST_OE_IN_SHIFT: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe |-> (state == ST_SH_IR || state == ST_SH_DR)); // R11

    AST_TLR_SELECTS_BYPASS: assert property (@(negedge tck) disable iff (!trst_n)
        (state == ST_TLR) |=> (sel == SEL_BYP && ir_q == OP_RESET)); // R2

    AST_IR_CAPTURE_PATTERN: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_CAP_IR) |=> (ir_sr == IR_CAPTURE)); // R3

    AST_BYPASS_ALIASES: assert property (@(negedge tck) disable iff (!trst_n)
        (state == ST_UPD_IR && ir_sr inside {3'b011, 3'b101, 3'b111}) |=> (sel == SEL_BYP)); // R4

    AST_NOOP_KEEPS_SELECTION: assert property (@(negedge tck) disable iff (!trst_n)
        (state == ST_UPD_IR && ir_sr inside {3'b000, 3'b001, 3'b110}) |=> $stable(sel)); // R7

    AST_DR_SCAN_KEEPS_IR: assert property (@(negedge tck) disable iff (!trst_n)
        (state inside {ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR, ST_UPD_DR})
        |=> $stable(ir_q)); // R10

    AST_DBG_STROBE_SOURCE: assert property (@(posedge tck) disable iff (!trst_n)
        dbg_upd |-> (state == ST_UPD_DR && sel == SEL_DBG)); // R8

    AST_PRG_STROBE_SOURCE: assert property (@(posedge tck) disable iff (!trst_n)
        prg_upd |-> (state == ST_UPD_DR && sel == SEL_PRG)); // R8

    AST_ONE_STROBE: assert property (@(negedge tck) disable iff (!trst_n)
        $onehot0({dbg_upd, prg_upd})); // R8

endmodule

bind jtag_tap_dr tap_checker u_chk (
    .tck(tck), .trst_n(trst_n), .state(state), .ir_sr(ir_sr), .ir_q(ir_q),
    .sel(sel), .tdo_oe(tdo_oe), .dbg_upd(dbg_upd), .prg_upd(prg_upd)
);

// File: tb/tb_jtag_tap_dr.sv
`timescale 1ns/1ps
module tb_jtag_tap_dr;

    logic       tck = 1'b0;
    logic       trst_n = 1'b0;
    logic       tms = 1'b1;
    logic       tdi = 1'b0;
    logic       tdo, tdo_oe;
    logic       dbg_upd, prg_upd;
    logic [9:0] dbg_wdata, dbg_load = '0;
    logic [2:0] prg_wdata, prg_load = '0;

    int checks = 0;
    int failures = 0;
    logic        last_tdo, last_oe;
    logic [15:0] scan_out;
    logic [2:0]  ir_out;

    jtag_tap_dr dut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
        .dbg_upd(dbg_upd), .dbg_wdata(dbg_wdata), .dbg_load(dbg_load),
        .prg_upd(prg_upd), .prg_wdata(prg_wdata), .prg_load(prg_load)
    );

    always #10 tck = ~tck;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One full TCK period: drive, rising edge, falling edge, then sample
    task automatic tick(input logic m, input logic d);
        tms = m; tdi = d;
        @(posedge tck); @(negedge tck); #1;
        last_tdo = tdo; last_oe = tdo_oe;
    endtask

    task automatic do_reset();
        trst_n = 1'b0;
        tick(1, 0); tick(1, 0);
        trst_n = 1'b1;
        tick(0, 0);
    endtask

    // IR-Scan from Run-Test/Idle; returns the captured pattern in ir_out
    task automatic ir_scan(input logic [2:0] code);
        tick(1, 0); tick(1, 0); tick(0, 0);
        tms = 0; tdi = 0;
        @(posedge tck); #1;
        chk("R11 oe before falling edge", {15'd0, tdo_oe}, 16'd0);
        @(negedge tck); #1;
        chk("R11 oe after falling edge", {15'd0, tdo_oe}, 16'd1);
        ir_out[0] = tdo;
        for (int i = 0; i < 3; i++) begin
            tick(i == 2, code[i]);
            if (i < 2) ir_out[i+1] = last_tdo;
        end
        chk("R11 oe low in Exit1-IR", {15'd0, last_oe}, 16'd0);
        tick(1, 0); tick(0, 0);
    endtask

    // DR-Scan of n bits from Run-Test/Idle; ends after the Update-DR falling edge
    task automatic dr_scan_to_update(input int n, input logic [15:0] din);
        tick(1, 0); tick(0, 0); tick(0, 0);
        scan_out = '0;
        scan_out[0] = last_tdo;
        for (int i = 0; i < n; i++) begin
            tick(i == n - 1, din[i]);
            if (i < n - 1) scan_out[i+1] = last_tdo;
        end
        tick(1, 0);
    endtask

    function automatic int decode(input logic [2:0] c, input int prev);
        case (c)
            3'b010: return 1;
            3'b100: return 2;
            3'b011, 3'b101, 3'b111: return 0;
            default: return prev;
        endcase
    endfunction

    function automatic int len_of(input int s);
        return (s == 1) ? 10 : (s == 2) ? 3 : 1;
    endfunction

    // Checks that bits at or above L are TDI delayed by L shifts
    task automatic chk_len(input string req, input int l, input logic [15:0] din);
        logic [15:0] exp, act;
        exp = '0; act = '0;
        for (int k = 0; k < 16; k++) if (k >= l) begin
            exp[k] = din[k-l];
            act[k] = scan_out[k];
        end
        chk(req, act, exp);
    endtask

    initial begin
        #(20 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] pat;
        int st, ex;
        logic [2:0] starts [3];
        starts[0] = 3'b011; starts[1] = 3'b010; starts[2] = 3'b100;

        do_reset();
        chk("R11 reset oe", {15'd0, tdo_oe}, 16'd0);
        chk("R8 reset strobes", {14'd0, dbg_upd, prg_upd}, 16'd0);

        // R2: the default path after reset is bypass, which captures 0 (R4)
        pat = 16'h5A3C;
        dr_scan_to_update(16, pat); tick(0, 0);
        chk("R2 default bypass capture bit", {15'd0, scan_out[0]}, 16'd0);
        chk_len("R2 default length 1", 1, pat);

        // R3 and R5: first debug scan reads the reset contents (zero)
        ir_scan(3'b010);
        chk("R3 capture-IR pattern", {13'd0, ir_out}, 16'd1);
        dbg_load = 10'h2A5;
        pat = 16'hC96B;
        dr_scan_to_update(16, pat);
        chk("R5 reset contents", {6'd0, scan_out[9:0]}, 16'd0);
        chk_len("R5 debug length 10", 10, pat);
        chk("R8 debug strobe", {14'd0, dbg_upd, prg_upd}, 16'b10);
        chk("R8 debug write word", {6'd0, dbg_wdata}, {6'd0, pat[15:6]});
        tick(0, 0);
        chk("R8 strobe one period", {15'd0, dbg_upd}, 16'd0);
        // R9: the load sampled at update is shifted out next
        dbg_load = 10'h0F0;
        dr_scan_to_update(16, 16'h1234); tick(0, 0);
        chk("R9 debug reload", {6'd0, scan_out[9:0]}, 16'h2A5);

        // R6 and R9 on the programming register
        ir_scan(3'b100);
        prg_load = 3'b101;
        pat = 16'h8E71;
        dr_scan_to_update(16, pat);
        chk_len("R6 prog length 3", 3, pat);
        chk("R8 prog strobe", {14'd0, dbg_upd, prg_upd}, 16'b01);
        chk("R8 prog write word", {13'd0, prg_wdata}, {13'd0, pat[15:13]});
        tick(0, 0);
        dr_scan_to_update(16, 16'h0000); tick(0, 0);
        chk("R9 prog reload", {13'd0, scan_out[2:0]}, 16'd5);

        // R10: a DR-Scan left in Pause-DR does not change the instruction,
        // so the path is still 3 bits long
        tick(1, 0); tick(0, 0); tick(0, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        tick(1, 0); tick(1, 0); tick(0, 0);
        pat = 16'h3C5A;
        dr_scan_to_update(16, pat); tick(0, 0);
        chk_len("R10 path kept after DR-Scan", 3, pat);

        // R1: five TMS=1 edges from inside Shift-DR reach Test-Logic-Reset,
        // which restores bypass (R2)
        tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < 5; i++) tick(1, 0);
        tick(0, 0);
        pat = 16'h9D27;
        dr_scan_to_update(16, pat); tick(0, 0);
        chk_len("R1 TMS reset gives bypass", 1, pat);

        // R1: trst_n from a shift state; oe drops, bypass restored
        ir_scan(3'b010);
        tick(1, 0); tick(0, 0); tick(0, 0);
        do_reset();
        chk("R1 trst oe low", {15'd0, tdo_oe}, 16'd0);
        pat = 16'h7713;
        dr_scan_to_update(16, pat); tick(0, 0);
        chk_len("R1 trst gives bypass", 1, pat);

        // R4 R5 R6 R7: every code after every prior selection
        for (int s = 0; s < 3; s++) begin
            for (int c = 0; c < 8; c++) begin
                do_reset();
                ir_scan(starts[s]);
                st = decode(starts[s], 0);
                ir_scan(3'(c));
                chk("R3 capture in sweep", {13'd0, ir_out}, 16'd1);
                ex = decode(3'(c), st);
                pat = 16'hA5C3 ^ 16'((s * 8 + c) * 16'h1357);
                dr_scan_to_update(16, pat);
                chk_len((ex == st && ex != 0) ? "R7 no-op keeps path" :
                        (ex == 0) ? "R4 bypass path" : "R5 R6 private path",
                        len_of(ex), pat);
                chk("R8 sweep strobes", {14'd0, dbg_upd, prg_upd},
                    (ex == 1) ? 16'b10 : (ex == 2) ? 16'b01 : 16'b00);
                if (ex == 0)
                    chk("R4 bypass captures 0", {15'd0, scan_out[0]}, 16'd0);
                tick(0, 0);
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule